// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial bit stream into parallel characters. A receive-clock tick input, one clock wide and running at 1, 16 or 64 times the bit rate, paces all sampling. At the two higher rates a falling start edge is checked again half a bit later. The line must still be low there, or the edge is dropped as noise. Each data bit is then sampled at its centre, counted from that start-bit midpoint.

The finished character moves from the assembly register into a holding register that the host reads, and the ready flag rises at that moment. The host clears ready with a read pulse. Parity, framing and overrun errors are held until the host issues an error-clear pulse or the block is reset. If a character completes while the previous one is still unread, the new character replaces the old one and the overrun flag is set. The framing controls are static inputs and must be held steady while a character is being received.

Top module: `osr_receiver`

## Requirements
- R1: After reset, rx_ready, err_parity, err_frame and err_overrun are low and rx_data is zero.
- R2: cfg_factor selects ticks per bit: code 0 is 1x, code 1 is 16x, codes 2 and 3 are 64x. At 16x and 64x every bit is sampled once, at its centre.
- R3: At 16x and 64x a start is recognised on the first tick that sees the line low. The line is sampled again half a bit later. If it is high there, the event is discarded: no character is delivered and no flag changes.
- R4: cfg_bits codes 0 to 3 select 5 to 8 data bits. Bits arrive least significant first and are right-aligned in rx_data, with the unused upper bits zero.
- R5: rx_ready rises in the clock cycle after the stop-bit sample. rx_data changes only in that cycle.
- R6: A host_read pulse clears rx_ready in the next cycle, unless a character completes in the same cycle.
- R7: A character that completes while rx_ready is high and no read is pending replaces rx_data and sets err_overrun.
- R8: With cfg_par_en high, one parity bit follows the last data bit. err_parity is set when the number of ones among the data and parity bits is odd (cfg_par_odd=0) or even (cfg_par_odd=1).
- R9: A stop bit sampled low sets err_frame. The character is still delivered.
- R10: The error flags stay set across host reads and further characters until err_clear or reset.
- R11: An err_clear pulse clears all three error flags in the next cycle. An error arriving in the same cycle takes precedence.
- R12: At 1x there is no midpoint check: the first low tick is taken as the start bit, and each later tick samples one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_tick | input | 1 | Receive sampling tick, one clock wide |
| rx_line | input | 1 | Serial receive line, idle high |
| cfg_factor | input | 2 | Oversampling factor code |
| cfg_bits | input | 2 | Data bits per character, code + 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when high, even when low |
| host_read | input | 1 | Host read strobe, clears ready |
| err_clear | input | 1 | Clears all error flags |
| rx_data | output | 8 | Holding register contents |
| rx_ready | output | 1 | Unread character present |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
A wrong tick count or a misplaced midpoint moves the sampling point into a neighbouring bit. The fault appears at the end of the frame as shifted data, a false parity error or a false framing error. A start-check fault shows up as a phantom character after a short low glitch, so rx_ready rises within one frame time. Faults in the holding stage are visible within a cycle or two of a read, clear or completion: ready failing to fall, a flag that drops without a clear, or a missing overrun on the second unread character.

// File: rtl/osr_pkg.sv
package osr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] FAC_X1  = 2'd0;
  localparam logic [1:0] FAC_X16 = 2'd1;
endpackage

// File: rtl/osr_sync.sv
module osr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= din;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/osr_framer.sv
module osr_framer
  import osr_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rxs,
  input  logic [1:0]          fac,
  input  logic [1:0]          bits_code,
  input  logic                pen,
  input  logic                podd,
  output logic                done,
  output logic [MAX_BITS-1:0] char_o,
  output logic                perr_o,
  output logic                ferr_o
);
  localparam int CNT_W = $clog2(SLOW_DIV);
  localparam int IDX_W = $clog2(MAX_BITS);
  localparam int NW    = IDX_W + 1;

  rx_state_e           st_q, st_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [IDX_W-1:0]    idx_q, idx_n;
  logic [MAX_BITS-1:0] sh_q, sh_n;
  logic                acc_q, acc_n;
  logic                armed_q, armed_n;
  logic                done_n;
  logic [MAX_BITS-1:0] char_n;
  logic                perr_n, ferr_n;

  logic [CNT_W-1:0]    lim, half;
  logic [NW-1:0]       nbits;
  logic [IDX_W-1:0]    last_idx;

  always_comb begin
    case (fac)
      FAC_X1: begin
        lim  = '0;
        half = '0;
      end
      FAC_X16: begin
        lim  = CNT_W'(FAST_DIV - 1);
        half = CNT_W'(FAST_DIV / 2 - 1);
      end
      default: begin
        lim  = CNT_W'(SLOW_DIV - 1);
        half = CNT_W'(SLOW_DIV / 2 - 1);
      end
    endcase
    nbits    = NW'(MIN_BITS) + NW'(bits_code);
    last_idx = IDX_W'(nbits - NW'(1));
  end

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    sh_n    = sh_q;
    acc_n   = acc_q;
    armed_n = armed_q;
    done_n  = 1'b0;
    char_n  = char_o;
    perr_n  = perr_o;
    ferr_n  = ferr_o;
    if (tick) begin
      case (st_q)
        ST_IDLE: begin
          if (rxs) begin
            armed_n = 1'b1;
          end else if (armed_q) begin
            armed_n = 1'b0;
            cnt_n   = '0;
            idx_n   = '0;
            acc_n   = 1'b0;
            st_n    = (fac == FAC_X1) ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (cnt_q == half) begin
            cnt_n = '0;
            st_n  = rxs ? ST_IDLE : ST_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == lim) begin
            cnt_n = '0;
            sh_n  = {rxs, sh_q[MAX_BITS-1:1]};
            acc_n = acc_q ^ rxs;
            if (idx_q == last_idx) st_n = pen ? ST_PAR : ST_STOP;
            else                   idx_n = idx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt_q == lim) begin
            cnt_n = '0;
            acc_n = acc_q ^ rxs;
            st_n  = ST_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == lim) begin
            cnt_n   = '0;
            done_n  = 1'b1;
            char_n  = sh_q >> (NW'(MAX_BITS) - nbits);
            perr_n  = pen & (acc_q ^ podd);
            ferr_n  = ~rxs;
            armed_n = rxs;
            st_n    = ST_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      armed_q <= 1'b1;
      done    <= 1'b0;
      char_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      sh_q    <= sh_n;
      acc_q   <= acc_n;
      armed_q <= armed_n;
      done    <= done_n;
      char_o  <= char_n;
      perr_o  <= perr_n;
      ferr_o  <= ferr_n;
    end
  end
endmodule

// File: rtl/osr_holding.sv
module osr_holding #(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] char_i,
  input  logic                perr_i,
  input  logic                ferr_i,
  input  logic                host_read,
  input  logic                err_clear,
  output logic [MAX_BITS-1:0] data_q,
  output logic                ready_q,
  output logic                par_q,
  output logic                frm_q,
  output logic                ovr_q
);
  logic [MAX_BITS-1:0] data_n;
  logic ready_n, par_n, frm_n, ovr_n;

  always_comb begin
    data_n  = data_q;
    ready_n = ready_q;
    par_n   = par_q;
    frm_n   = frm_q;
    ovr_n   = ovr_q;
    if (host_read) ready_n = 1'b0;
    if (err_clear) begin
      par_n = 1'b0;
      frm_n = 1'b0;
      ovr_n = 1'b0;
    end
    if (load) begin
      data_n  = char_i;
      ready_n = 1'b1;
      if (perr_i) par_n = 1'b1;
      if (ferr_i) frm_n = 1'b1;
      if (ready_q && !host_read) ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      par_q   <= 1'b0;
      frm_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      data_q  <= data_n;
      ready_q <= ready_n;
      par_q   <= par_n;
      frm_q   <= frm_n;
      ovr_q   <= ovr_n;
    end
  end
endmodule

// File: rtl/osr_receiver.sv
module osr_receiver #(
  parameter int MAX_BITS    = 8,
  parameter int MIN_BITS    = 5,
  parameter int FAST_DIV    = 16,
  parameter int SLOW_DIV    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_tick,
  input  logic                rx_line,
  input  logic [1:0]          cfg_factor,
  input  logic [1:0]          cfg_bits,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                host_read,
  input  logic                err_clear,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_ready,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun
);
  logic                rx_s;
  logic                fr_done;
  logic [MAX_BITS-1:0] fr_char;
  logic                fr_perr, fr_ferr;

  osr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (rx_s)
  );

  osr_framer #(
    .MAX_BITS(MAX_BITS),
    .MIN_BITS(MIN_BITS),
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (rx_tick),
    .rxs      (rx_s),
    .fac      (cfg_factor),
    .bits_code(cfg_bits),
    .pen      (cfg_par_en),
    .podd     (cfg_par_odd),
    .done     (fr_done),
    .char_o   (fr_char),
    .perr_o   (fr_perr),
    .ferr_o   (fr_ferr)
  );

  osr_holding #(.MAX_BITS(MAX_BITS)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fr_done),
    .char_i   (fr_char),
    .perr_i   (fr_perr),
    .ferr_i   (fr_ferr),
    .host_read(host_read),
    .err_clear(err_clear),
    .data_q   (rx_data),
    .ready_q  (rx_ready),
    .par_q    (err_parity),
    .frm_q    (err_frame),
    .ovr_q    (err_overrun)
  );
endmodule

// File: rtl/osr_receiver_chk.sv
module osr_receiver_chk #(
  parameter int MAX_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_read,
  input logic                err_clear,
  input logic                fr_done,
  input logic [MAX_BITS-1:0] rx_data,
  input logic                rx_ready,
  input logic                err_parity,
  input logic                err_frame,
  input logic                err_overrun
);
  // R5: ready only rises one cycle after a completed character
  a_r5_ready_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(fr_done));

  // R5: holding register only changes on a load
  a_r5_data_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $past(fr_done));

  // R6: a read without a simultaneous completion empties the buffer
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_read && !fr_done) |=> !rx_ready);

  // R7: completion onto an unread character flags overrun
  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && rx_ready && !host_read) |=> err_overrun);

  // R10: error flags fall only after a clear request
  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_parity) || $fell(err_frame) || $fell(err_overrun)) |-> $past(err_clear));

  // R11: clear with no competing completion empties all flags
  a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !fr_done) |=> (!err_parity && !err_frame && !err_overrun));
endmodule

bind osr_receiver osr_receiver_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_read  (host_read),
  .err_clear  (err_clear),
  .fr_done    (fr_done),
  .rx_data    (rx_data),
  .rx_ready   (rx_ready),
  .err_parity (err_parity),
  .err_frame  (err_frame),
  .err_overrun(err_overrun)
);

// File: tb/tb_osr_receiver.sv
module tb_osr_receiver;
  logic       clk;
  logic       rst_n;
  logic       rx_tick;
  logic       rx_line;
  logic [1:0] cfg_factor;
  logic [1:0] cfg_bits;
  logic       cfg_par_en;
  logic       cfg_par_odd;
  logic       host_read;
  logic       err_clear;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       err_parity;
  logic       err_frame;
  logic       err_overrun;

  int checks;
  int fails;

  osr_receiver dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_tick    (rx_tick),
    .rx_line    (rx_line),
    .cfg_factor (cfg_factor),
    .cfg_bits   (cfg_bits),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .host_read  (host_read),
    .err_clear  (err_clear),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_overrun(err_overrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0] fac;
    logic [1:0] bits;
    logic       pen;
    logic       podd;
    logic       stopv;
    logic       badpar;
    logic [7:0] data;
    logic [7:0] exp_data;
    logic       exp_pe;
    logic       exp_fe;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
    '{2'd2, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0},
    '{2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h55, 8'h55, 1'b0, 1'b0},
    '{2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF6, 8'h16, 1'b0, 1'b0},
    '{2'd1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 8'h81, 1'b1, 1'b0},
    '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2A, 8'h2A, 1'b0, 1'b1},
    '{2'd3, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0A, 8'h0A, 1'b1, 1'b0},
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 8'hC3, 1'b0, 1'b1}
  };

  task automatic check(input logic ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_ticks(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      rx_line = lvl;
      repeat (3) @(negedge clk);
      rx_tick = 1'b1;
      @(negedge clk);
      rx_tick = 1'b0;
    end
  endtask

  task automatic send_frame(input logic [1:0] fac, input logic [1:0] bits,
                            input logic pen, input logic podd, input logic stopv,
                            input logic badpar, input logic [7:0] data);
    int   n;
    int   nb;
    logic p;
    n  = (fac == 2'd0) ? 1 : (fac == 2'd1) ? 16 : 64;
    nb = 5 + int'(bits);
    p  = podd;
    cfg_factor  = fac;
    cfg_bits    = bits;
    cfg_par_en  = pen;
    cfg_par_odd = podd;
    drive_ticks(1'b0, n);
    for (int b = 0; b < nb; b++) begin
      drive_ticks(data[b], n);
      p = p ^ data[b];
    end
    if (pen) drive_ticks(p ^ badpar, n);
    drive_ticks(stopv, n);
    drive_ticks(1'b1, (n == 1) ? 2 : n);
  endtask

  task automatic pulse_read;
    host_read = 1'b1;
    @(negedge clk);
    host_read = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clear;
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks      = 0;
    fails       = 0;
    rst_n       = 1'b0;
    rx_tick     = 1'b0;
    rx_line     = 1'b1;
    cfg_factor  = 2'd1;
    cfg_bits    = 2'd3;
    cfg_par_en  = 1'b0;
    cfg_par_odd = 1'b0;
    host_read   = 1'b0;
    err_clear   = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(rx_ready == 1'b0, "R1 ready", 8'(rx_ready), 8'h0);
    check({err_parity, err_frame, err_overrun} == 3'b000, "R1 flags",
          8'({err_parity, err_frame, err_overrun}), 8'h0);
    check(rx_data == 8'h00, "R1 data", rx_data, 8'h00);

    // Vector table walk
    foreach (VECS[k]) begin
      send_frame(VECS[k].fac, VECS[k].bits, VECS[k].pen, VECS[k].podd,
                 VECS[k].stopv, VECS[k].badpar, VECS[k].data);
      check(rx_ready == 1'b1, "R5 ready after frame", 8'(rx_ready), 8'h1);
      if (VECS[k].fac == 2'd0)
        check(rx_data == VECS[k].exp_data, "R12 R4 data", rx_data, VECS[k].exp_data);
      else
        check(rx_data == VECS[k].exp_data, "R2 R4 data", rx_data, VECS[k].exp_data);
      check(err_parity == VECS[k].exp_pe, "R8 parity flag", 8'(err_parity), 8'(VECS[k].exp_pe));
      check(err_frame == VECS[k].exp_fe, "R9 framing flag", 8'(err_frame), 8'(VECS[k].exp_fe));
      check(err_overrun == 1'b0, "R7 no overrun", 8'(err_overrun), 8'h0);
      pulse_read;
      check(rx_ready == 1'b0, "R6 read clears ready", 8'(rx_ready), 8'h0);
      if (VECS[k].exp_pe || VECS[k].exp_fe)
        check(err_parity == VECS[k].exp_pe && err_frame == VECS[k].exp_fe,
              "R10 flags survive read", 8'({err_parity, err_frame}),
              8'({VECS[k].exp_pe, VECS[k].exp_fe}));
      pulse_clear;
      check({err_parity, err_frame, err_overrun} == 3'b000, "R11 clear",
            8'({err_parity, err_frame, err_overrun}), 8'h0);
    end

    // R3 short low glitch at 16x is rejected
    cfg_factor = 2'd1;
    cfg_bits   = 2'd3;
    cfg_par_en = 1'b0;
    drive_ticks(1'b0, 4);
    drive_ticks(1'b1, 40);
    check(rx_ready == 1'b0, "R3 glitch no char", 8'(rx_ready), 8'h0);
    check({err_parity, err_frame, err_overrun} == 3'b000, "R3 glitch no flags",
          8'({err_parity, err_frame, err_overrun}), 8'h0);
    send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
    check(rx_ready == 1'b1 && rx_data == 8'h5A, "R3 frame after glitch", rx_data, 8'h5A);
    pulse_read;

    // R7 overrun, R10 sticky across read, R11 clear
    send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11);
    send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22);
    check(err_overrun == 1'b1, "R7 overrun set", 8'(err_overrun), 8'h1);
    check(rx_data == 8'h22, "R7 newer char kept", rx_data, 8'h22);
    check(rx_ready == 1'b1, "R5 ready on overrun", 8'(rx_ready), 8'h1);
    pulse_read;
    check(rx_ready == 1'b0, "R6 ready cleared", 8'(rx_ready), 8'h0);
    check(err_overrun == 1'b1, "R10 overrun sticky", 8'(err_overrun), 8'h1);
    send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h33);
    check(err_overrun == 1'b1, "R10 sticky after new char", 8'(err_overrun), 8'h1);
    pulse_read;
    pulse_clear;
    check(err_overrun == 1'b0, "R11 overrun cleared", 8'(err_overrun), 8'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule